// File: doc/BRIEF.md
# Interrupt Distributor Control Register Slice

This block is the register slice of an interrupt distributor that software reaches over a simple register bus. It holds three global words and a bank of routing registers. The control word holds the group-1 enable. The type word tells software how many interrupt lines exist, how wide an interrupt ID is and whether message-signalled interrupts are supported. The identification word is constant. There is one 64-bit routing register for each shared interrupt, and it holds the three low affinity bytes of the core that should receive that interrupt. Enable, pending and priority state, and the mapping from an affinity to a core index, are not part of this slice.

The bus has a byte address, 32-bit write data, a two-bit access size and separate read and write strobes. Read data is registered and returned one cycle after the read strobe, with `rvalid_o` set. When the enable bit goes from 0 to 1, the block raises `wake_o` for one cycle so that the rest of the distributor can deliver interrupts that were waiting. A 64-bit routing access is made as two 32-bit beats, one to each half of the slot.

The address map is as follows. The control group takes bytes 0x000 to 0x00F: word 0 is control, word 1 is type, word 2 is identification and word 3 is unimplemented. The routing window starts at `ROUTE_BASE` and holds 1024 slots of 8 bytes each. Slot k belongs to interrupt ID k. Only slots 32 to 32+`NUM_SHARED`-1 are implemented.

Top module: `intdist_regs`

## Requirements
- R1: In the control word, bit 1 is the writable enable, and bits 4 and 6 always read as one. Every other bit reads as zero. A write changes the enable only when it is a full-word access (size 2'b10) to byte offset 0x0.
- R2: `wake_o` is high for exactly the one cycle after a write that changes the enable from 0 to 1. A write that leaves the enable unchanged, or clears it, gives no pulse.
- R3: Bits 4:0 of the type word equal ((`NUM_SHARED` + 32) >> 5) - 1.
- R4: Bits 23:19 of the type word hold the interrupt ID width minus one. The width is 16 when `MSG_IRQ_EN` is 1 and 10 otherwise. Bit 17 is one exactly when `MSG_IRQ_EN` is 1.
- R5: The identification word reads as `PRODUCT_CODE` in bits 31:24 and `IMPL_CODE` in bits 11:0. Writes to the type word and the identification word have no effect.
- R6: An aligned full-word write to the lower word of an implemented routing slot stores bits 23:0 of the write data. A later word read of that lower word returns those bits, with bits 31:24 read as zero.
- R7: The upper word of every routing slot (address bit 2 set) reads as zero, and writes to it change nothing.
- R8: A read returns the register's bytes starting at byte offset addr[2:0] for routing slots, or addr[1:0] for the control group. Size 2'b00 returns 1 byte, 2'b01 returns 2 bytes and 2'b10 returns 4 bytes, right-aligned. Any byte past the end of the register reads as zero.
- R9: Offset 0x00C, routing slots 0 to 31, slots past the implemented range and any address outside both regions read as zero, and writes to them change nothing.
- R10: After reset, the enable bit and every routing affinity are zero, and `rvalid_o`, `rdata_o` and `wake_o` are low.
- R11: `rvalid_o` is high in the cycle after each read strobe and low otherwise. `rdata_o` holds the data of the last read.
- R12: A routing write that is not a full word at byte offset 0 of the slot leaves the stored affinity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| size_i | input | 2 | Access size: 00 byte, 01 half, 10 word |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_i` |
| wake_o | output | 1 | One-cycle pulse when the enable goes from 0 to 1 |

## Verification
The bench walks every routing slot from ID 0 up to two slots past the implemented range. Each slot's lower word gets a distinct ID-derived pattern with the top byte set, and each upper word gets a fixed pattern. This separates correct slot selection from aliasing, shows that the top byte is discarded and shows that the upper word cannot be written. Every slot is then read at all eight byte offsets and with half-word reads, which checks the byte-extraction rule and the zero fill past bit 23. A sub-word write that should be ignored is also tried. On the control word the bench writes set, same-value, clear and all-ones patterns, which tells a pulse on a real 0-to-1 change apart from a pulse on every write. Two instances, one with message support and one without, show that both type-word variants are built.

// File: rtl/intdist_pkg.sv
package intdist_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam int SLOT_FIRST  = 32;
    localparam int SLOT_TOTAL  = 1024;
    localparam int SLOT_BITS   = 10;
    localparam int AFF_W       = 24;

    typedef struct packed {
        logic                 is_ctrl;
        logic [1:0]           ctrl_sel;
        logic                 is_route;
        logic                 upper;
        logic [SLOT_BITS-1:0] slot;
        logic [2:0]           byte_off;
    } dec_t;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
    } rd_state_t;

    typedef struct packed {
        logic en;
        logic wake;
    } ctrl_state_t;

endpackage

// File: rtl/intdist_decode.sv
module intdist_decode
    import intdist_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_SHARED = 32,
    parameter int ROUTE_BASE = 'h6000
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int SPAN      = SLOT_TOTAL * 8;
    localparam int SLOT_LAST = SLOT_FIRST + NUM_SHARED - 1;

    logic [SLOT_BITS-1:0] slot_d;
    logic                 in_win_d;

    always_comb begin
        in_win_d = (32'(addr_i) >= 32'(ROUTE_BASE)) &&
                   (32'(addr_i) <  32'(ROUTE_BASE + SPAN));
        slot_d   = SLOT_BITS'((32'(addr_i) - 32'(ROUTE_BASE)) >> 3);

        dec_o          = '0;
        dec_o.is_ctrl  = ((addr_i >> 4) == '0);
        dec_o.ctrl_sel = addr_i[3:2];
        dec_o.slot     = slot_d;
        dec_o.upper    = addr_i[2];
        dec_o.byte_off = addr_i[2:0];
        dec_o.is_route = in_win_d &&
                         (32'(slot_d) >= 32'(SLOT_FIRST)) &&
                         (32'(slot_d) <= 32'(SLOT_LAST));
    end

endmodule

// File: rtl/intdist_ctrl.sv
module intdist_ctrl
    import intdist_pkg::*;
#(
    parameter int          NUM_SHARED   = 32,
    parameter bit          MSG_IRQ_EN   = 1'b1,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic        wr_bit_i,
    output logic [31:0] ctrl_word_o,
    output logic [31:0] type_word_o,
    output logic [31:0] ident_word_o,
    output logic        wake_o
);
    localparam int          EN_BIT    = 1;
    localparam int          ROUTE_BIT = 4;
    localparam int          NOSEC_BIT = 6;
    localparam int          LINES_M1  = ((NUM_SHARED + SLOT_FIRST) >> 5) - 1;
    localparam int          ID_W      = MSG_IRQ_EN ? 16 : 10;
    localparam logic [31:0] TYPE_WORD = (32'(LINES_M1) & 32'h1F)
                                      | (32'(ID_W - 1) << 19)
                                      | (MSG_IRQ_EN ? (32'h1 << 17) : 32'h0);
    localparam logic [31:0] IDENT_WORD = {PRODUCT_CODE, 12'h000, IMPL_CODE};

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (wr_en_i) begin
            st_d.en   = wr_bit_i;
            st_d.wake = wr_bit_i && !st_q.en;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        ctrl_word_o            = '0;
        ctrl_word_o[EN_BIT]    = st_q.en;
        ctrl_word_o[ROUTE_BIT] = 1'b1;
        ctrl_word_o[NOSEC_BIT] = 1'b1;
    end

    assign type_word_o  = TYPE_WORD;
    assign ident_word_o = IDENT_WORD;
    assign wake_o       = st_q.wake;

    AST_WAKE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wake |-> (st_q.en && !$past(st_q.en))); // R2
    AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wake |=> !st_q.wake); // R2

endmodule

// File: rtl/intdist_route_bank.sv
module intdist_route_bank
    import intdist_pkg::*;
#(
    parameter int NUM_SHARED = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_en_i,
    input  logic [SLOT_BITS-1:0]        slot_i,
    input  logic [AFF_W-1:0]            wdata_i,
    output logic [AFF_W-1:0]            rd_aff_o,
    output logic [NUM_SHARED*AFF_W-1:0] aff_flat_o
);
    logic [AFF_W-1:0]     aff_d [NUM_SHARED];
    logic [AFF_W-1:0]     aff_q [NUM_SHARED];
    logic [SLOT_BITS-1:0] rel;

    assign rel = slot_i - SLOT_BITS'(SLOT_FIRST);

    always_comb begin
        for (int i = 0; i < NUM_SHARED; i++) begin
            aff_d[i] = aff_q[i];
            if (wr_en_i && (rel == SLOT_BITS'(i))) aff_d[i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_SHARED; i++) aff_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_SHARED; i++) aff_q[i] <= aff_d[i];
        end
    end

    always_comb begin
        rd_aff_o = '0;
        for (int i = 0; i < NUM_SHARED; i++) begin
            if (rel == SLOT_BITS'(i)) rd_aff_o = aff_q[i];
        end
    end

    for (genvar g = 0; g < NUM_SHARED; g++) begin : g_flat
        assign aff_flat_o[g*AFF_W +: AFF_W] = aff_q[g];
    end

    AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(aff_flat_o)); // R12

endmodule

// File: rtl/intdist_regs.sv
module intdist_regs
    import intdist_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          NUM_SHARED   = 32,
    parameter bit          MSG_IRQ_EN   = 1'b1,
    parameter int          ROUTE_BASE   = 'h6000,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [1:0]        size_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [31:0]       rdata_o,
    output logic              rvalid_o,
    output logic              wake_o
);
    dec_t                        dec;
    logic [31:0]                 ctrl_word, type_word, ident_word;
    logic [AFF_W-1:0]            rd_aff;
    logic [NUM_SHARED*AFF_W-1:0] aff_flat;
    logic                        ctrl_wr, route_wr, word_acc;
    logic [7:0]                  wdata_unused;
    rd_state_t                   rs_d, rs_q;
    logic [63:0]                 slot64, shifted;
    logic [2:0]                  off;
    logic [31:0]                 mask;

    assign wdata_unused = wdata_i[31:24];

    intdist_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_SHARED(NUM_SHARED),
        .ROUTE_BASE(ROUTE_BASE)
    ) u_decode (
        .addr_i(addr_i),
        .dec_o (dec)
    );

    assign word_acc = (acc_size_e'(size_i) == SZ_WORD) && (dec.byte_off[1:0] == 2'b00);
    assign ctrl_wr  = wr_i && dec.is_ctrl && (dec.ctrl_sel == 2'd0) && word_acc;
    assign route_wr = wr_i && dec.is_route && !dec.upper && word_acc;

    intdist_ctrl #(
        .NUM_SHARED  (NUM_SHARED),
        .MSG_IRQ_EN  (MSG_IRQ_EN),
        .PRODUCT_CODE(PRODUCT_CODE),
        .IMPL_CODE   (IMPL_CODE)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (ctrl_wr),
        .wr_bit_i    (wdata_i[1]),
        .ctrl_word_o (ctrl_word),
        .type_word_o (type_word),
        .ident_word_o(ident_word),
        .wake_o      (wake_o)
    );

    intdist_route_bank #(
        .NUM_SHARED(NUM_SHARED)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (route_wr),
        .slot_i    (dec.slot),
        .wdata_i   (wdata_i[AFF_W-1:0]),
        .rd_aff_o  (rd_aff),
        .aff_flat_o(aff_flat)
    );

    always_comb begin
        slot64 = '0;
        off    = {1'b0, dec.byte_off[1:0]};
        if (dec.is_ctrl) begin
            case (dec.ctrl_sel)
                2'd0:    slot64 = {32'h0, ctrl_word};
                2'd1:    slot64 = {32'h0, type_word};
                2'd2:    slot64 = {32'h0, ident_word};
                default: slot64 = '0;
            endcase
        end else if (dec.is_route) begin
            slot64 = {40'h0, rd_aff};
            off    = dec.byte_off;
        end
        shifted = slot64 >> {off, 3'b000};
        case (acc_size_e'(size_i))
            SZ_BYTE: mask = 32'h0000_00FF;
            SZ_HALF: mask = 32'h0000_FFFF;
            default: mask = 32'hFFFF_FFFF;
        endcase

        rs_d        = rs_q;
        rs_d.rvalid = rd_i;
        if (rd_i) rs_d.rdata = shifted[31:0] & mask;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rs_q <= '0;
        else         rs_q <= rs_d;
    end

    assign rdata_o  = rs_q.rdata;
    assign rvalid_o = rs_q.rvalid;

    AST_RVALID_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> rvalid_o); // R11
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> !rvalid_o); // R11
    AST_FIXED_CTRL_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && dec.is_ctrl && dec.ctrl_sel == 2'd0 && word_acc) |=> (rdata_o[4] && rdata_o[6])); // R1
    AST_UPPER_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && dec.is_route && dec.upper) |=> (rdata_o == 32'h0)); // R7
    AST_UPPER_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && dec.upper) |=> $stable(aff_flat)); // R7
    AST_AFF_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && dec.is_route && word_acc) |=> (rdata_o[31:24] == 8'h0)); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !dec.is_ctrl && !dec.is_route) |=> (rdata_o == 32'h0)); // R9

endmodule

// File: tb/intdist_regs_test.sv
`timescale 1ns/1ps
module intdist_regs_test;
    localparam int NS   = 32;
    localparam int BASE = 'h6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  size = 2'b10;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] rdata, rdata_nm;
    logic        rvalid, rvalid_nm, wake, wake_nm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intdist_regs #(.NUM_SHARED(NS), .MSG_IRQ_EN(1'b1)) uut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .size_i(size),
        .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .rvalid_o(rvalid), .wake_o(wake));

    intdist_regs #(.NUM_SHARED(NS), .MSG_IRQ_EN(1'b0)) uut_nomsg (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .size_i(size),
        .wr_i(wr), .rd_i(rd), .rdata_o(rdata_nm), .rvalid_o(rvalid_nm), .wake_o(wake_nm));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d,
                            input logic [1:0] s, output logic pulse);
        @(negedge clk);
        addr = a; wdata = d; size = s; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        pulse = wake;
    endtask

    task automatic do_read(input string req, input logic [15:0] a, input logic [1:0] s,
                           input logic [31:0] exp);
        @(negedge clk);
        addr = a; size = s; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R11", {31'h0, rvalid}, 32'h1);
        check(req, rdata, exp);
    endtask

    function automatic logic [31:0] pat(input int id);
        return (32'(id) * 32'h0003_1B07) ^ 32'hFF5A_C3E1;
    endfunction

    function automatic logic [63:0] stored(input int id);
        if (id >= 32 && id < 32 + NS) return {40'h0, pat(id)[23:0]};
        return 64'h0;
    endfunction

    initial begin
        logic p;
        logic [31:0] tword;
        #1;
        repeat (3) @(negedge clk);
        check("R10 rdata", rdata, 32'h0);
        check("R10 rvalid", {31'h0, rvalid}, 32'h0);
        check("R10 wake", {31'h0, wake}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle", {31'h0, rvalid}, 32'h0);

        do_read("R10 R1 ctrl", 16'h0000, 2'b10, 32'h0000_0050);
        do_read("R10 route", 16'(BASE + 8*32), 2'b10, 32'h0);

        do_write(16'h0000, 32'h0000_0002, 2'b10, p);
        check("R2 rise pulse", {31'h0, p}, 32'h1);
        @(negedge clk);
        check("R2 pulse width", {31'h0, wake}, 32'h0);
        do_read("R1 enabled", 16'h0000, 2'b10, 32'h0000_0052);
        do_write(16'h0000, 32'h0000_0002, 2'b10, p);
        check("R2 same value", {31'h0, p}, 32'h0);
        do_write(16'h0000, 32'h0000_0000, 2'b10, p);
        check("R2 clear", {31'h0, p}, 32'h0);
        do_read("R1 cleared", 16'h0000, 2'b10, 32'h0000_0050);
        do_write(16'h0000, 32'h0000_00FF, 2'b00, p);
        check("R1 byte write ignored", {31'h0, p}, 32'h0);
        do_read("R1 after byte write", 16'h0000, 2'b10, 32'h0000_0050);
        do_write(16'h0000, 32'hFFFF_FFFF, 2'b10, p);
        check("R2 all ones", {31'h0, p}, 32'h1);
        do_read("R1 all ones", 16'h0000, 2'b10, 32'h0000_0052);
        do_read("R8 ctrl byte0", 16'h0000, 2'b00, 32'h0000_0052);
        do_read("R8 ctrl byte1", 16'h0001, 2'b00, 32'h0);
        do_read("R8 ctrl half at 3", 16'h0003, 2'b01, 32'h0);

        tword = (32'(((NS + 32) >> 5) - 1) & 32'h1F) | (32'(16 - 1) << 19) | (32'h1 << 17);
        do_read("R3 R4 type msg", 16'h0004, 2'b10, tword);
        @(negedge clk);
        addr = 16'h0004; size = 2'b10; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R4 type no msg", rdata_nm,
              (32'(((NS + 32) >> 5) - 1) & 32'h1F) | (32'(10 - 1) << 19));
        do_write(16'h0004, 32'h0, 2'b10, p);
        do_read("R5 type write ignored", 16'h0004, 2'b10, tword);
        do_read("R5 ident", 16'h0008, 2'b10, 32'h4B00_043B);
        do_write(16'h0008, 32'h1234_5678, 2'b10, p);
        do_read("R5 ident write ignored", 16'h0008, 2'b10, 32'h4B00_043B);
        do_write(16'h000C, 32'hFFFF_FFFF, 2'b10, p);
        do_read("R9 ctrl hole", 16'h000C, 2'b10, 32'h0);
        do_read("R9 outside", 16'h0100, 2'b10, 32'h0);

        for (int id = 0; id < 32 + NS + 2; id++) begin
            do_write(16'(BASE + 8*id), pat(id), 2'b10, p);
            do_write(16'(BASE + 8*id + 4), 32'hDEAD_BEEF, 2'b10, p);
            do_write(16'(BASE + 8*id), 32'h0, 2'b00, p);
            do_write(16'(BASE + 8*id + 1), 32'h0, 2'b10, p);
        end
        for (int id = 0; id < 32 + NS + 2; id++) begin
            logic [63:0] v;
            v = stored(id);
            do_read((id >= 32 && id < 32 + NS) ? "R6 R12 lower word" : "R9 unimplemented slot",
                    16'(BASE + 8*id), 2'b10, v[31:0]);
            do_read("R7 upper word", 16'(BASE + 8*id + 4), 2'b10, 32'h0);
            for (int o = 0; o < 8; o++) begin
                logic [63:0] sh;
                sh = v >> (8*o);
                do_read("R8 byte", 16'(BASE + 8*id + o), 2'b00, {24'h0, sh[7:0]});
            end
            begin
                logic [63:0] sh;
                sh = v >> 8;
                do_read("R8 half", 16'(BASE + 8*id + 1), 2'b01, {16'h0, sh[15:0]});
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule